// File: doc/BRIEF.md
# Masked Dual Alarm Comparator and Interrupt Router

This block watches a BCD calendar time that a separate counter updates once per second. On every such update it compares the newly presented time against two alarm register sets: the first covers seconds, minutes, hours and a day-or-date field; the second covers minutes, hours and a day-or-date field and fires only on the second where the seconds read 00. A mask bit in each alarm byte drops that field from the comparison, which turns a full time match into a periodic alarm.

A match sets a sticky flag per alarm, and software clears it by writing 0. The flags pass through per-alarm enables to two active-low open-drain interrupt lines. Each line is modelled as an output enable that is high while the pin is pulled low. A routing bit picks one of two layouts. In one, each alarm owns its own line. In the other, both alarms share the first line and the second line carries a square wave chosen from four prescaler taps.

Top module: `alarm_irq_router`

## Requirements
- R1: When `sec_tick` is 1 and every unmasked field of alarm 1 equals the current time, flag bit 0 reads 1 from the next cycle. Seconds, minutes and hours compare on bits 6:0.
- R2: A mask bit (bit 7 of an alarm byte) of 1 removes that field from the comparison. With all four alarm 1 masks set, alarm 1 matches on every tick.
- R3: In the day/date alarm byte, bit 6 set to 1 compares bits 5:0 with the day-of-week input. Bit 6 set to 0 compares bits 5:0 with the day-of-month input.
- R4: Alarm 2 matches only when the current seconds are 00. With its three masks set, it therefore matches once per minute.
- R5: Matches are evaluated only in cycles where `sec_tick` is 1. A matching time without a tick leaves the flags unchanged.
- R6: Flags stay at 1 until a write to `flag_we` carries 0 in that bit position. A 1 in `flag_wdata` leaves the flag unchanged.
- R7: If a match and a clearing write hit the same flag in the same cycle, the flag reads 1 afterwards.
- R8: With the route bit (`cfg_q[2]`) at 1, `irq_a_oe` equals flag0 AND enable1 (`cfg_q[0]`), and `irq_b_oe` equals flag1 AND enable2 (`cfg_q[1]`).
- R9: With the route bit at 0, `irq_a_oe` is the OR of both enabled flags. `irq_b_oe` is the inverse of the tap that the rate field `cfg_q[4:3]` selects: 00 picks tap 0 (1 Hz), 01 picks tap 1 (4.096 kHz), 10 picks tap 2 (8.192 kHz) and 11 picks tap 3 (32.768 kHz).
- R10: After reset, `cfg_q` is 5'b11000 (rate 11, route 0, both enables 0) and both flags are 0.
- R11: The enable bits gate only the interrupt lines. Flags set and hold whatever the enables are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | Once-per-second update strobe; time inputs already hold the new value |
| now_sec | input | 8 | Current seconds, BCD |
| now_min | input | 8 | Current minutes, BCD |
| now_hour | input | 8 | Current hours with mode bits |
| now_wday | input | 8 | Current day of week |
| now_mday | input | 8 | Current day of month, BCD |
| a1_sec | input | 8 | Alarm 1 seconds byte, bit 7 mask |
| a1_min | input | 8 | Alarm 1 minutes byte, bit 7 mask |
| a1_hour | input | 8 | Alarm 1 hours byte, bit 7 mask |
| a1_dd | input | 8 | Alarm 1 day/date byte, bit 7 mask, bit 6 select |
| a2_min | input | 8 | Alarm 2 minutes byte, bit 7 mask |
| a2_hour | input | 8 | Alarm 2 hours byte, bit 7 mask |
| a2_dd | input | 8 | Alarm 2 day/date byte, bit 7 mask, bit 6 select |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 5 | Configuration write data {rate[1:0], route, en2, en1} |
| flag_we | input | 1 | Flag write strobe |
| flag_wdata | input | 2 | Flag write data; 0 clears, 1 keeps |
| sqw_taps | input | 4 | Prescaler taps, index equals rate code |
| cfg_q | output | 5 | Configuration register contents |
| flag_q | output | 2 | Sticky alarm flags {alarm2, alarm1} |
| irq_a_oe | output | 1 | Pull-low enable of the first interrupt line |
| irq_b_oe | output | 1 | Pull-low enable of the second line (interrupt or square wave) |

## Verification
Every cycle, the assertions check that flags change only through a tick or a clear, that a flag holds without a clear, that a clear without a tick takes effect, and that an active interrupt line is always backed by a raised flag. Only the bench scenarios can show which mask, day/date and seconds patterns count as matches, that the set-over-clear priority holds, and that each rate code selects its tap. They also show the reset contents and the routing under both values of the route bit.

// File: rtl/alm_pkg.sv
package alm_pkg;
  localparam int BCD_W    = 8;
  localparam int MASK_BIT = BCD_W - 1;
  localparam int SEL_BIT  = BCD_W - 2;
  localparam int NUM_ALM  = 2;
  localparam int NUM_TAP  = 4;
  localparam int RATE_W   = $clog2(NUM_TAP);

  typedef struct packed {
    logic [RATE_W-1:0] rate;
    logic              route;
    logic              en2;
    logic              en1;
  } alm_cfg_t;

  localparam int CFG_W = $bits(alm_cfg_t);

  localparam alm_cfg_t CFG_RST = '{rate: '1, route: 1'b0, en2: 1'b0, en1: 1'b0};
endpackage

// File: rtl/alm_match.sv
module alm_match
  import alm_pkg::*;
#(
  parameter bit HAS_SEC = 1'b1
) (
  input  logic [BCD_W-1:0] now_sec,
  input  logic [BCD_W-1:0] now_min,
  input  logic [BCD_W-1:0] now_hour,
  input  logic [BCD_W-1:0] now_wday,
  input  logic [BCD_W-1:0] now_mday,
  input  logic [BCD_W-1:0] alm_sec,
  input  logic [BCD_W-1:0] alm_min,
  input  logic [BCD_W-1:0] alm_hour,
  input  logic [BCD_W-1:0] alm_dd,
  output logic             hit
);
  localparam int VAL_W = MASK_BIT;
  localparam int DD_W  = SEL_BIT;

  logic sec_ok, min_ok, hour_ok, dd_ok;
  logic [DD_W-1:0] dd_ref;

  generate
    if (HAS_SEC) begin : g_sec_field
      always_comb sec_ok = alm_sec[MASK_BIT] || (alm_sec[VAL_W-1:0] == now_sec[VAL_W-1:0]);
    end else begin : g_sec_zero
      always_comb sec_ok = (now_sec[VAL_W-1:0] == '0);
    end
  endgenerate

  always_comb begin
    min_ok  = alm_min[MASK_BIT]  || (alm_min[VAL_W-1:0]  == now_min[VAL_W-1:0]);
    hour_ok = alm_hour[MASK_BIT] || (alm_hour[VAL_W-1:0] == now_hour[VAL_W-1:0]);
    dd_ref  = alm_dd[SEL_BIT] ? now_wday[DD_W-1:0] : now_mday[DD_W-1:0];
    dd_ok   = alm_dd[MASK_BIT] || (alm_dd[DD_W-1:0] == dd_ref);
    hit     = sec_ok && min_ok && hour_ok && dd_ok;
  end

  logic unused_bits;
  assign unused_bits = ^{now_sec[MASK_BIT], now_min[MASK_BIT], now_hour[MASK_BIT],
                         now_wday[BCD_W-1:DD_W], now_mday[BCD_W-1:DD_W], alm_sec};
endmodule

// File: rtl/alm_flags.sv
module alm_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [N-1:0] hit,
  input  logic         clr_we,
  input  logic [N-1:0] clr_wdata,
  output logic [N-1:0] flag_q
);
  logic [N-1:0] flag_d;
  logic [N-1:0] set_v, clr_v;

  always_comb begin
    set_v  = hit & {N{tick}};
    clr_v  = ~clr_wdata & {N{clr_we}};
    flag_d = (flag_q & ~clr_v) | set_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end
endmodule

// File: rtl/alm_cfg_reg.sv
module alm_cfg_reg
  import alm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     we,
  input  alm_cfg_t wdata,
  output alm_cfg_t cfg_q
);
  alm_cfg_t cfg_d;

  always_comb cfg_d = we ? wdata : cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= CFG_RST;
    else        cfg_q <= cfg_d;
  end
endmodule

// File: rtl/sqw_select.sv
module sqw_select
  import alm_pkg::*;
(
  input  logic [NUM_TAP-1:0] taps,
  input  logic [RATE_W-1:0]  rate,
  output logic               wave
);
  always_comb begin
    wave = 1'b0;
    for (int i = 0; i < NUM_TAP; i++) begin
      if (rate == RATE_W'(i)) wave = taps[i];
    end
  end
endmodule

// File: rtl/alarm_irq_router.sv
module alarm_irq_router
  import alm_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sec_tick,
  input  logic [BCD_W-1:0]    now_sec,
  input  logic [BCD_W-1:0]    now_min,
  input  logic [BCD_W-1:0]    now_hour,
  input  logic [BCD_W-1:0]    now_wday,
  input  logic [BCD_W-1:0]    now_mday,
  input  logic [BCD_W-1:0]    a1_sec,
  input  logic [BCD_W-1:0]    a1_min,
  input  logic [BCD_W-1:0]    a1_hour,
  input  logic [BCD_W-1:0]    a1_dd,
  input  logic [BCD_W-1:0]    a2_min,
  input  logic [BCD_W-1:0]    a2_hour,
  input  logic [BCD_W-1:0]    a2_dd,
  input  logic                cfg_we,
  input  logic [CFG_W-1:0]    cfg_wdata,
  input  logic                flag_we,
  input  logic [NUM_ALM-1:0]  flag_wdata,
  input  logic [NUM_TAP-1:0]  sqw_taps,
  output logic [CFG_W-1:0]    cfg_q,
  output logic [NUM_ALM-1:0]  flag_q,
  output logic                irq_a_oe,
  output logic                irq_b_oe
);
  logic [NUM_ALM-1:0] hit;
  logic [NUM_ALM-1:0] en_v;
  logic [NUM_ALM-1:0] live;
  alm_cfg_t           cfg;
  logic               wave;

  logic [NUM_ALM-1:0][BCD_W-1:0] sel_sec, sel_min, sel_hour, sel_dd;

  always_comb begin
    sel_sec[0] = a1_sec;  sel_min[0] = a1_min;  sel_hour[0] = a1_hour; sel_dd[0] = a1_dd;
    sel_sec[1] = '0;      sel_min[1] = a2_min;  sel_hour[1] = a2_hour; sel_dd[1] = a2_dd;
  end

  generate
    for (genvar g = 0; g < NUM_ALM; g++) begin : g_alarm
      alm_match #(.HAS_SEC(g == 0)) u_match (
        .now_sec  (now_sec),
        .now_min  (now_min),
        .now_hour (now_hour),
        .now_wday (now_wday),
        .now_mday (now_mday),
        .alm_sec  (sel_sec[g]),
        .alm_min  (sel_min[g]),
        .alm_hour (sel_hour[g]),
        .alm_dd   (sel_dd[g]),
        .hit      (hit[g])
      );
    end
  endgenerate

  alm_flags #(.N(NUM_ALM)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (sec_tick),
    .hit       (hit),
    .clr_we    (flag_we),
    .clr_wdata (flag_wdata),
    .flag_q    (flag_q)
  );

  alm_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (alm_cfg_t'(cfg_wdata)),
    .cfg_q (cfg)
  );

  sqw_select u_sqw (
    .taps (sqw_taps),
    .rate (cfg.rate),
    .wave (wave)
  );

  always_comb begin
    cfg_q = cfg;
    en_v  = {cfg.en2, cfg.en1};
    live  = flag_q & en_v;
    if (cfg.route) begin
      irq_a_oe = live[0];
      irq_b_oe = live[1];
    end else begin
      irq_a_oe = |live;
      irq_b_oe = ~wave;
    end
  end
endmodule

// File: rtl/alm_router_chk.sv
module alm_router_chk
  import alm_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               sec_tick,
  input logic               flag_we,
  input logic [NUM_ALM-1:0] flag_wdata,
  input logic [CFG_W-1:0]   cfg_q,
  input logic [NUM_ALM-1:0] flag_q,
  input logic               irq_a_oe
);
  // R5: no tick means a clear flag cannot rise
  assert_no_set_without_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_tick && !flag_q[0]) |=> !flag_q[0]);

  // R6: a raised flag holds unless a 0 is written to it
  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q[1] && !(flag_we && !flag_wdata[1])) |=> flag_q[1]);

  // R6: a clearing write without a tick takes effect
  assert_clear_effect_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && !flag_wdata[0] && !sec_tick) |=> !flag_q[0]);

  // R8 and R9: the first line is only active when some flag is raised
  assert_irq_a_backed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_a_oe |-> (flag_q != '0));

  // R11: with both enables off the first line stays released
  assert_irq_a_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[1:0] == 2'b00) |-> !irq_a_oe);
endmodule

bind alarm_irq_router alm_router_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sec_tick   (sec_tick),
  .flag_we    (flag_we),
  .flag_wdata (flag_wdata),
  .cfg_q      (cfg_q),
  .flag_q     (flag_q),
  .irq_a_oe   (irq_a_oe)
);

// File: tb/alarm_irq_router_test.sv
module alarm_irq_router_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       sec_tick;
  logic [7:0] now_sec, now_min, now_hour, now_wday, now_mday;
  logic [7:0] a1_sec, a1_min, a1_hour, a1_dd, a2_min, a2_hour, a2_dd;
  logic       cfg_we;
  logic [4:0] cfg_wdata;
  logic       flag_we;
  logic [1:0] flag_wdata;
  logic [3:0] sqw_taps;
  logic [4:0] cfg_q;
  logic [1:0] flag_q;
  logic       irq_a_oe, irq_b_oe;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  alarm_irq_router uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_time(input logic [7:0] s, m, h, wd, md);
    now_sec = s; now_min = m; now_hour = h; now_wday = wd; now_mday = md;
  endtask

  task automatic pulse_tick();
    @(negedge clk) sec_tick = 1'b1;
    @(negedge clk) sec_tick = 1'b0;
  endtask

  task automatic write_flags(input logic [1:0] d);
    @(negedge clk) begin flag_we = 1'b1; flag_wdata = d; end
    @(negedge clk) flag_we = 1'b0;
  endtask

  task automatic write_cfg(input logic [4:0] d);
    @(negedge clk) begin cfg_we = 1'b1; cfg_wdata = d; end
    @(negedge clk) cfg_we = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10 cfg", cfg_q, 5'b11000);
    chk("R10 flags", flag_q, 2'b00);
    chk("R10 irq_a", irq_a_oe, 1'b0);
  endtask

  task automatic t_exact_a1();
    a1_sec = 8'h56; a1_min = 8'h34; a1_hour = 8'h12; a1_dd = 8'h15;
    a2_min = 8'h59; a2_hour = 8'h23; a2_dd = 8'h31;
    set_time(8'h55, 8'h34, 8'h12, 8'h02, 8'h15);
    pulse_tick();
    chk("R1 seconds differ", flag_q, 2'b00);
    set_time(8'h56, 8'h34, 8'h12, 8'h02, 8'h15);
    pulse_tick();
    chk("R1 full match", flag_q, 2'b01);
    write_flags(2'b00);
    chk("R6 cleared", flag_q, 2'b00);
  endtask

  task automatic t_no_tick();
    @(negedge clk);
    @(negedge clk);
    chk("R5 no tick no set", flag_q, 2'b00);
  endtask

  task automatic t_masks();
    a1_sec = 8'h80; a1_min = 8'h80; a1_hour = 8'h80; a1_dd = 8'h80;
    set_time(8'h07, 8'h08, 8'h09, 8'h04, 8'h22);
    pulse_tick();
    chk("R2 all masked", flag_q[0], 1'b1);
    write_flags(2'b00);
    a1_sec = 8'h07; a1_min = 8'h08; a1_hour = 8'h95; a1_dd = 8'h81;
    pulse_tick();
    chk("R2 hour and day masked", flag_q[0], 1'b1);
    write_flags(2'b00);
    a1_hour = 8'h15;
    pulse_tick();
    chk("R2 hour unmasked differs", flag_q[0], 1'b0);
  endtask

  task automatic t_daydate();
    a1_sec = 8'h80; a1_min = 8'h80; a1_hour = 8'h80; a1_dd = 8'h43;
    set_time(8'h00, 8'h00, 8'h00, 8'h03, 8'h20);
    pulse_tick();
    chk("R3 day select match", flag_q[0], 1'b1);
    write_flags(2'b10);
    chk("R6 partial clear", flag_q[0], 1'b0);
    a1_dd = 8'h03;
    pulse_tick();
    chk("R3 date select mismatch", flag_q[0], 1'b0);
    a1_dd = 8'h20;
    pulse_tick();
    chk("R3 date select match", flag_q[0], 1'b1);
    write_flags(2'b00);
  endtask

  task automatic t_alarm2();
    a1_sec = 8'h11; a1_min = 8'h00; a1_hour = 8'h00; a1_dd = 8'h01;
    a2_min = 8'h80; a2_hour = 8'h80; a2_dd = 8'h80;
    set_time(8'h01, 8'h10, 8'h05, 8'h01, 8'h05);
    pulse_tick();
    chk("R4 seconds not zero", flag_q, 2'b00);
    now_sec = 8'h00;
    pulse_tick();
    chk("R4 once per minute", flag_q, 2'b10);
    write_flags(2'b00);
    a2_min = 8'h10; a2_hour = 8'h06;
    pulse_tick();
    chk("R4 hour differs", flag_q, 2'b00);
    a2_hour = 8'h05;
    pulse_tick();
    chk("R4 min hour match", flag_q, 2'b10);
  endtask

  task automatic t_sticky();
    now_sec = 8'h30;
    pulse_tick();
    chk("R6 holds after nonmatch tick", flag_q, 2'b10);
    write_flags(2'b11);
    chk("R6 write one no effect", flag_q, 2'b10);
    write_flags(2'b00);
    chk("R6 write zero clears", flag_q, 2'b00);
  endtask

  task automatic t_set_wins();
    now_sec = 8'h00;
    @(negedge clk) begin sec_tick = 1'b1; flag_we = 1'b1; flag_wdata = 2'b00; end
    @(negedge clk) begin sec_tick = 1'b0; flag_we = 1'b0; end
    chk("R7 set beats clear", flag_q, 2'b10);
  endtask

  task automatic t_route();
    a1_sec = 8'h80; a1_min = 8'h80; a1_hour = 8'h80; a1_dd = 8'h80;
    pulse_tick();
    chk("R11 flags set with enables off", flag_q, 2'b11);
    chk("R11 irq_a released", irq_a_oe, 1'b0);
    write_cfg(5'b00111);
    chk("R8 irq_a", irq_a_oe, 1'b1);
    chk("R8 irq_b", irq_b_oe, 1'b1);
    write_flags(2'b01);
    chk("R8 irq_b follows flag1", irq_b_oe, 1'b0);
    chk("R8 irq_a still", irq_a_oe, 1'b1);
    write_cfg(5'b00101);
    chk("R8 en gating", irq_b_oe, 1'b0);
    pulse_tick();
    write_flags(2'b10);
    write_cfg(5'b00010);
    chk("R9 shared line alarm2", irq_a_oe, 1'b1);
    write_cfg(5'b00001);
    chk("R9 shared line disabled", irq_a_oe, 1'b0);
    chk("R11 flag kept", flag_q, 2'b10);
    write_flags(2'b00);
  endtask

  task automatic t_sqw();
    for (int r = 0; r < 4; r++) begin
      write_cfg({2'(r), 3'b000});
      for (int p = 0; p < 2; p++) begin
        @(negedge clk) sqw_taps = (p == 0) ? (4'b1 << r) : ~(4'b1 << r);
        #1 chk("R9 square wave tap", irq_b_oe, (p == 0) ? 1'b0 : 1'b1);
      end
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sec_tick = 1'b0; cfg_we = 1'b0; cfg_wdata = '0;
    flag_we = 1'b0; flag_wdata = '1; sqw_taps = 4'b0111;
    set_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h01);
    a1_sec = 8'h59; a1_min = 8'h59; a1_hour = 8'h23; a1_dd = 8'h31;
    a2_min = 8'h59; a2_hour = 8'h23; a2_dd = 8'h31;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    chk("R9 reset square wave tap3", irq_b_oe, 1'b1);
    t_exact_a1();
    a1_sec = 8'h56; a1_min = 8'h34; a1_hour = 8'h12; a1_dd = 8'h15;
    set_time(8'h56, 8'h34, 8'h12, 8'h02, 8'h15);
    t_no_tick();
    t_masks();
    t_daydate();
    t_alarm2();
    t_sticky();
    t_set_wins();
    write_flags(2'b00);
    t_route();
    t_sqw();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule